// File: doc/BRIEF.md
# Asynchronous SRAM Module Controller

This block sits between a simple valid/ready host port and an external asynchronous static RAM module. The module holds 131,072 words of 64 bits. Each of its eight byte lanes has its own active-low write strobe, and the module has one shared active-low chip enable and one output enable. The host presents a read or a write command with a 17-bit word address, 64 bits of write data and an 8-bit byte mask. The controller then runs the access on the memory pins. It keeps each minimum timing window of the chosen speed grade, measured in whole clock cycles.

The clock period and the speed grade (70 or 100) are parameters. Every nanosecond minimum is rounded up to whole cycles. The write window uses the largest of four minimums: write pulse, address valid to end of write, chip enable to end of write, and data valid to end of write. The read sampling point comes from the address access time. The bus turnaround wait comes from the output-disable-to-high-Z time.

The data bus is split into three signals: an output value, an output enable and an input value. These are joined into one bidirectional bus at the pad. All memory-side controls are registered, so they cannot glitch.

Top module: `sram_module_ctrl`

## Requirements
- R1: During and right after reset, these outputs are as follows: chip enable, output enable and all eight write strobes high; bus drive enable low; ready high; response valid low.
- R2: A command is taken only on a clock edge where req_valid and req_ready are both high. From the next cycle, ready stays low until the whole access (turnaround included) is over. A request held high while ready is low leaves the memory pins unchanged.
- R3: A write runs as follows. There is one setup cycle with chip enable low, bus driven and strobes high. Then WP cycles with the selected strobes low. Then one recovery cycle with strobes high and the bus still driven. The bus is released in the next cycle, where ready is high again. WP = ceil(max(tWP, tAW, tCW, tDW) / clock period). For grade 70 these are 55, 60, 60 and 30 ns; for grade 100 they are 70, 80, 80 and 40 ns.
- R4: Write strobe bit i goes low only if byte mask bit i is 1. Bit i writes byte lane i, which is data bits 8i+7 down to 8i.
- R5: The address and bus write data match the accepted command, and they stay unchanged from the setup cycle through the recovery cycle.
- R6: A read holds chip enable and output enable low, with strobes high and the bus not driven, for RD = ceil(tAA / clock period) cycles. tAA is 70 or 100 ns. The input bus is sampled on the edge that ends the last of those cycles.
- R7: The sampled read data appears for exactly one cycle, with rsp_valid high, in the cycle after the last read cycle. Ready is also high in that cycle.
- R8: A write accepted when the previous access was a read first spends TA = ceil(tOHZ / clock period) cycles with all controls high and the bus not driven. tOHZ is 25 or 30 ns. A write after a write, or the first access after reset, has no such wait.
- R9: Bus drive and memory output enable are never active in the same cycle. No write strobe is low while chip enable is high or output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host command present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte mask, bit i selects lane i |
| req_ready | output | 1 | Controller can take a command |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 64 | Read data |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 8 | Per-lane write strobes, active low |
| mem_addr | output | 17 | Memory address |
| mem_dq_out | output | 64 | Data toward the memory |
| mem_dq_oe | output | 1 | Pad drive enable for the data bus |
| mem_dq_in | input | 64 | Data from the memory |

## Verification
The overlap that matters is the read-data valid pulse and the acceptance of the next command. Both happen in the same cycle, and when the next command is a write, the turnaround choice is made in that cycle too. The bench provokes this by issuing a write in the exact cycle where a read's response is shown. It compares every memory pin, cycle by cycle, against a queue of expected vectors, which must show the TA undriven cycles before the setup cycle. The bench's memory model returns junk until RD cycles of stable read mode have passed, so a read sampled early returns the wrong data. Requests held high while the controller is busy, and a write with an empty mask, are judged by the same per-cycle comparison.

// File: rtl/sram_module_ctrl.sv
module sram_module_ctrl #(
  parameter int CLK_NS = 10,
  parameter int GRADE  = 70,
  parameter int AW     = 17,
  parameter int LANES  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [AW-1:0]        req_addr,
  input  logic [LANES*8-1:0]   req_wdata,
  input  logic [LANES-1:0]     req_be,
  output logic                 req_ready,
  output logic                 rsp_valid,
  output logic [LANES*8-1:0]   rsp_rdata,
  output logic                 mem_ce_n,
  output logic                 mem_oe_n,
  output logic [LANES-1:0]     mem_we_n,
  output logic [AW-1:0]        mem_addr,
  output logic [LANES*8-1:0]   mem_dq_out,
  output logic                 mem_dq_oe,
  input  logic [LANES*8-1:0]   mem_dq_in
);
  localparam int DW     = LANES * 8;
  localparam int T_WP   = (GRADE == 100) ? 70 : 55;
  localparam int T_AW   = (GRADE == 100) ? 80 : 60;
  localparam int T_DW   = (GRADE == 100) ? 40 : 30;
  localparam int T_AA   = (GRADE == 100) ? 100 : 70;
  localparam int T_OHZ  = (GRADE == 100) ? 30 : 25;
  localparam int T_WIN  = (T_WP > T_AW) ? ((T_WP > T_DW) ? T_WP : T_DW)
                                        : ((T_AW > T_DW) ? T_AW : T_DW);
  localparam int WP_RAW = (T_WIN + CLK_NS - 1) / CLK_NS;
  localparam int RD_RAW = (T_AA + CLK_NS - 1) / CLK_NS;
  localparam int TA_CYC = (T_OHZ + CLK_NS - 1) / CLK_NS;
  localparam int WP_CYC = (WP_RAW < 1) ? 1 : WP_RAW;
  localparam int RD_CYC = (RD_RAW < 1) ? 1 : RD_RAW;
  localparam int MAXC   = (WP_CYC > RD_CYC) ? ((WP_CYC > TA_CYC) ? WP_CYC : TA_CYC)
                                            : ((RD_CYC > TA_CYC) ? RD_CYC : TA_CYC);
  localparam int CW     = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_TURN, S_WSET, S_WSTB, S_WREC, S_READ} st_t;

  st_t            st, st_n;
  logic [CW-1:0]  cnt, cnt_n;
  logic           after_rd;
  logic [LANES-1:0] be_q;
  logic           take;
  logic           last_rd;

  assign take    = req_valid && req_ready;
  assign last_rd = (st == S_READ) && (cnt == '0);

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    case (st)
      S_IDLE:
        if (take) begin
          if (!req_write) begin
            st_n  = S_READ;
            cnt_n = CW'(RD_CYC - 1);
          end else if (after_rd && TA_CYC > 0) begin
            st_n  = S_TURN;
            cnt_n = CW'(TA_CYC - 1);
          end else begin
            st_n = S_WSET;
          end
        end
      S_TURN:
        if (cnt == '0) st_n = S_WSET;
        else cnt_n = cnt - 1'b1;
      S_WSET: begin
        st_n  = S_WSTB;
        cnt_n = CW'(WP_CYC - 1);
      end
      S_WSTB:
        if (cnt == '0) st_n = S_WREC;
        else cnt_n = cnt - 1'b1;
      S_WREC: st_n = S_IDLE;
      S_READ:
        if (cnt == '0) st_n = S_IDLE;
        else cnt_n = cnt - 1'b1;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      after_rd   <= 1'b0;
      be_q       <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      req_ready  <= 1'b1;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= '1;
      mem_dq_oe  <= 1'b0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
      if (take) begin
        after_rd   <= !req_write;
        be_q       <= req_be;
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      rsp_valid <= last_rd;
      if (last_rd) rsp_rdata <= mem_dq_in;
      req_ready <= (st_n == S_IDLE);
      mem_ce_n  <= !(st_n inside {S_WSET, S_WSTB, S_WREC, S_READ});
      mem_oe_n  <= (st_n != S_READ);
      mem_dq_oe <= (st_n inside {S_WSET, S_WSTB, S_WREC});
      mem_we_n  <= (st_n == S_WSTB) ? ~be_q : '1;
    end
  end

  // R9
  strobe_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n != '1) |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

  // R9
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  // R3
  drive_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (mem_we_n == '1));

  // R3
  release_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dq_oe) |-> ($past(mem_we_n) == '1));

  // R8
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(mem_oe_n));

  // R5
  stable_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n != '1 && $past(mem_we_n) != '1) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/sram_module_ctrl_test.sv
module sram_module_ctrl_test;
  localparam int CLK_NS = 20;
  localparam int WIN_NS = 60;
  localparam int AA_NS  = 70;
  localparam int OHZ_NS = 25;
  localparam int WP = (WIN_NS + CLK_NS - 1) / CLK_NS;
  localparam int RD = (AA_NS + CLK_NS - 1) / CLK_NS;
  localparam int TA = (OHZ_NS + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_be = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_dq_oe;
  logic [63:0] rsp_rdata, mem_dq_out;
  logic [63:0] mem_dq_in = '0;
  logic [7:0]  mem_we_n;
  logic [16:0] mem_addr;

  sram_module_ctrl #(.CLK_NS(CLK_NS), .GRADE(70)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic rdy, rv, ce_n, oe_n;
    logic [7:0] we_n;
    logic dqoe;
    logic [16:0] addr;
    logic [63:0] dq;
    logic [63:0] rd;
  } vec_t;

  vec_t q[$];
  logic [63:0] shadow[int];
  logic [63:0] dev[int];
  int n_cmp = 0, n_bad = 0, rcnt = 0;
  bit chk_on = 0, done = 0, m_after_rd = 0;

  function automatic vec_t idle(input logic [23:0] t);
    vec_t v = '0;
    v.tag = t; v.rdy = 1; v.ce_n = 1; v.oe_n = 1; v.we_n = '1;
    return v;
  endfunction

  task automatic chk(input logic [23:0] tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      vec_t e;
      e = (q.size() > 0) ? q.pop_front() : idle("R2");
      chk(e.tag, "ready", 64'(req_ready), 64'(e.rdy));
      chk(e.tag, "rsp_valid", 64'(rsp_valid), 64'(e.rv));
      chk(e.tag, "ce_n", 64'(mem_ce_n), 64'(e.ce_n));
      chk(e.tag, "oe_n", 64'(mem_oe_n), 64'(e.oe_n));
      chk(e.tag, "we_n", 64'(mem_we_n), 64'(e.we_n));
      chk(e.tag, "dq_oe", 64'(mem_dq_oe), 64'(e.dqoe));
      if (!e.ce_n) chk(e.tag, "addr", 64'(mem_addr), 64'(e.addr));
      if (e.dqoe)  chk(e.tag, "dq_out", mem_dq_out, e.dq);
      if (e.rv)    chk(e.tag, "rdata", rsp_rdata, e.rd);
      // R9 never drive while the memory may drive
      chk("R9", "contention", 64'(mem_dq_oe & ~mem_oe_n), 64'd0);
    end
    if (!mem_ce_n && !mem_oe_n && mem_we_n == '1) rcnt++;
    else rcnt = 0;
    for (int b = 0; b < 8; b++)
      if (!mem_ce_n && !mem_we_n[b]) begin
        logic [63:0] w;
        w = dev.exists(int'(mem_addr)) ? dev[int'(mem_addr)] : 64'd0;
        w[8*b +: 8] = mem_dq_oe ? mem_dq_out[8*b +: 8] : 8'hxx;
        dev[int'(mem_addr)] = w;
      end
    if (rcnt >= RD)
      mem_dq_in = dev.exists(int'(mem_addr)) ? dev[int'(mem_addr)] : 64'd0;
    else
      mem_dq_in = 64'hDEAD_BEEF_0BAD_F00D;
  end

  task automatic issue(input bit wr, input logic [16:0] a,
                       input logic [63:0] d, input logic [7:0] be);
    vec_t v;
    while (q.size() > 1) begin @(posedge clk); #5; end
    if (q.size() == 0) q.push_back(idle("R2"));
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    if (wr) begin
      if (m_after_rd)
        for (int i = 0; i < TA; i++) begin
          v = idle("R8"); v.rdy = 0; q.push_back(v);
        end
      v = '0; v.tag = "R3"; v.ce_n = 0; v.oe_n = 1; v.we_n = '1; v.dqoe = 1;
      v.addr = a; v.dq = d;
      q.push_back(v);
      for (int i = 0; i < WP; i++) begin
        v.tag = "R4"; v.we_n = ~be; q.push_back(v);
      end
      v.tag = "R5"; v.we_n = '1; q.push_back(v);
      q.push_back(idle("R3"));
      begin
        logic [63:0] w;
        w = shadow.exists(int'(a)) ? shadow[int'(a)] : 64'd0;
        for (int b = 0; b < 8; b++) if (be[b]) w[8*b +: 8] = d[8*b +: 8];
        shadow[int'(a)] = w;
      end
      m_after_rd = 0;
    end else begin
      v = '0; v.tag = "R6"; v.ce_n = 0; v.oe_n = 0; v.we_n = '1; v.addr = a;
      for (int i = 0; i < RD; i++) q.push_back(v);
      v = idle("R7"); v.rv = 1;
      v.rd = shadow.exists(int'(a)) ? shadow[int'(a)] : 64'd0;
      q.push_back(v);
      m_after_rd = 1;
    end
    @(posedge clk); #5;
    req_valid = 0;
  endtask

  task automatic busy_noise(input logic [16:0] a);
    while (q.size() > 2) begin
      req_valid = 1; req_write = 0; req_addr = a; req_wdata = 64'hFFFF_0000_FFFF_0000;
      req_be = 8'hFF;
      @(posedge clk); #5;
    end
    req_valid = 0;
  endtask

  task automatic gap(input int n);
    repeat (n) begin @(posedge clk); #5; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "ce_n", 64'(mem_ce_n), 64'd1);
    chk("R1", "oe_n", 64'(mem_oe_n), 64'd1);
    chk("R1", "we_n", 64'(mem_we_n), 64'hFF);
    chk("R1", "dq_oe", 64'(mem_dq_oe), 64'd0);
    chk("R1", "ready", 64'(req_ready), 64'd1);
    chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    @(posedge clk); #5;
    rst_n = 1; chk_on = 1;
    gap(2);
    // R1 right after release
    chk("R1", "we_n", 64'(mem_we_n), 64'hFF);
    issue(1, 17'h00012, 64'h0123_4567_89AB_CDEF, 8'hFF);
    issue(0, 17'h00012, '0, '0);
    // R8 write in the response cycle of a read
    issue(1, 17'h00012, 64'h1111_2222_3333_4444, 8'h0F);
    // R4 write after write, sparse mask
    issue(1, 17'h00012, 64'hAAAA_BBBB_CCCC_DDDD, 8'hA0);
    issue(0, 17'h00012, '0, '0);
    gap(3);
    // R2 busy requests ignored
    issue(1, 17'h1FFFF, 64'hFEED_FACE_CAFE_BABE, 8'h81);
    busy_noise(17'h00005);
    issue(0, 17'h1FFFF, '0, '0);
    busy_noise(17'h00006);
    issue(0, 17'h00000, '0, '0);
    issue(0, 17'h1FFFF, '0, '0);
    gap(TA + 2);
    // R4 empty mask writes nothing
    issue(1, 17'h00012, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
    issue(0, 17'h00012, '0, '0);
    for (int k = 0; k < 12; k++) begin
      logic [16:0] a;
      a = 17'(k * 9973);
      issue(1, a, {32'(k * 77), 32'(~k)}, 8'(k * 37 + 1));
      issue(0, a, '0, '0);
    end
    while (q.size() > 0) begin @(posedge clk); #5; end
    gap(3);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule